// File: doc/BRIEF.md
# Video Output Formatter with Luma/Chroma Alignment

This block is the last pixel-rate stage ahead of a component video output. It accepts an 8-bit luma stream, an 8-bit chroma stream that alternately carries the two colour-difference components, and a marker that is high while a line is in its active region. All inputs move one sample per clock. Each stream runs through a short delay line. A tap multiplexer picks the delay for each stream, so chroma can trail luma, luma can trail chroma, and the active marker can move earlier or later. A clamp then keeps every video sample inside a selectable code range, so the codes reserved for timing references never appear in the data.

An 8-bit control register sets the block up. Software writes it and reads it back through a small register port. The register holds two signed 3-bit offsets (luma/chroma skew and active-start shift), a clamp range select, and a mode bit for the downstream line-length recovery logic. The block only stores that mode bit and drives it out as a pin. The two offsets and the range select reach the datapath only at the start of a line. This keeps a register write made partway through a line from splitting that line between two settings.

Top module: `vid_out_fmt`

## Requirements
- R1: The control register resets to 0x00. A write with `cfg_we` high at a clock edge is returned on `cfg_rdata` after that edge.
- R2: Register bit 0 is driven on `err_mode` straight from the register, with no wait for a line start. Setting it has no effect on the video outputs.
- R3: Register bits 4:2 hold a two's-complement skew d. Luma latency is 3 + max(-d,0) clocks and chroma latency is 3 + max(d,0) clocks. So codes 001/010/011 make chroma trail luma by 1/2/3 clocks, and codes 111/110/101 make luma trail chroma by 1/2/3 clocks.
- R4: Code 100 in either signed field behaves exactly like code 000: both streams get the base latency of 3 clocks.
- R5: Register bits 7:5 hold a two's-complement shift a. `act_out` equals `act_in` delayed by 3 + a clocks, so positive codes start active video later and negative codes start it earlier.
- R6: With register bit 1 at 0, every `y_out` and `c_out` sample is clamped to the range 1..254.
- R7: With register bit 1 at 1, `y_out` is clamped to 16..235 and every `c_out` sample, whichever colour component it carries, is clamped to 16..240.
- R8: Clamping is applied to the sample the skew tap selected, that is, after alignment, under any combination of settings.
- R9: The skew, shift and range fields take effect only when `act_in` is sampled high after being low. The register value held at that edge is used from the next clock on. At all other times a register write leaves the video outputs unchanged.
- R10: During reset `y_out`, `c_out` and `act_out` are 0, and the delay lines are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write value |
| cfg_rdata | output | 8 | Register read value |
| err_mode | output | 1 | Line-length recovery mode (register bit 0) |
| y_in | input | 8 | Luma sample |
| c_in | input | 8 | Multiplexed chroma sample |
| act_in | input | 1 | Active-region marker in |
| y_out | output | 8 | Aligned, clamped luma |
| c_out | output | 8 | Aligned, clamped chroma |
| act_out | output | 1 | Shifted active-region marker |

## Verification
A sample driven before clock edge n appears on `y_out` after edge n+3+max(-d,0) and on `c_out` after edge n+3+max(d,0). The marker appears on `act_out` after edge n+3+a. The register readback and `err_mode` change after the same edge that takes the write. The bench keeps an eight-entry history of inputs, indexed by edge count. For each edge it computes the expected output from that history and the setting in force at that edge. It samples the outputs at the following falling edge. A new setting is modelled as active from the edge after the line-start sample, so outputs during a change-over are compared against the exact tap mix the requirements define.

// File: rtl/vof_pkg.sv
package vof_pkg;

   // Control register layout; field positions are decoded by software.
   typedef struct packed {
      logic [2:0] act_code;   // bits 7:5 active-start shift
      logic [2:0] yc_code;    // bits 4:2 luma/chroma skew
      logic       range_sel;  // bit 1 clamp range
      logic       err_mode;   // bit 0 line recovery mode
   } vof_cfg_t;

   // Signed 3-bit code to offset; 100 maps to zero, magnitude limited.
   function automatic int code_to_offset(input logic [2:0] code, input int lim);
      int v;
      v = code[2] ? (int'(code) - 8) : int'(code);
      if (code == 3'b100) v = 0;
      if (v > lim) v = lim;
      if (v < -lim) v = -lim;
      return v;
   endfunction

endpackage

// File: rtl/vof_cfg_reg.sv
module vof_cfg_reg
   import vof_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       err_mode,
   input  logic       act_in,
   output logic [2:0] eff_act_code,
   output logic [2:0] eff_yc_code,
   output logic       eff_range_sel
);

   vof_cfg_t   live_q;
   logic       act_prev_q;
   logic [2:0] sh_act_q;
   logic [2:0] sh_yc_q;
   logic       sh_rng_q;
   logic       line_start;

   assign line_start = act_in && !act_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q     <= '0;
         act_prev_q <= 1'b0;
         sh_act_q   <= '0;
         sh_yc_q    <= '0;
         sh_rng_q   <= 1'b0;
      end else begin
         if (we) live_q <= vof_cfg_t'(wdata);
         if (line_start) begin
            sh_act_q <= live_q.act_code;
            sh_yc_q  <= live_q.yc_code;
            sh_rng_q <= live_q.range_sel;
         end
         act_prev_q <= act_in;
      end
   end

   assign rdata         = live_q;
   assign err_mode      = live_q.err_mode;
   assign eff_act_code  = sh_act_q;
   assign eff_yc_code   = sh_yc_q;
   assign eff_range_sel = sh_rng_q;

   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata == $past(wdata)));

   a_r2_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (err_mode == $past(wdata[0])));

   a_r9_hold_mid_line: assert property (@(posedge clk) disable iff (!rst_n)
      (act_prev_q || !act_in) |=>
         ($stable(eff_act_code) && $stable(eff_yc_code) && $stable(eff_range_sel)));

endmodule

// File: rtl/vof_tap_line.sv
module vof_tap_line #(
   parameter int W     = 8,
   parameter int DEPTH = 7,
   localparam int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     din,
   input  logic [TAP_W-1:0] tap,
   output logic [W-1:0]     dout
);

   if (W < 1) begin : g_bad_w
      $error("vof_tap_line: W must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("vof_tap_line: DEPTH must be at least 1");
   end

   if (DEPTH > 1) begin : g_line
      logic [W-1:0] dly [1:DEPTH-1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 1; k < DEPTH; k++) dly[k] <= '0;
         end else begin
            dly[1] <= din;
            for (int k = 2; k < DEPTH; k++) dly[k] <= dly[k-1];
         end
      end

      always_comb begin
         dout = din;
         for (int k = 1; k < DEPTH; k++) begin
            if (tap == TAP_W'(k)) dout = dly[k];
         end
      end

      a_r3_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         32'(tap) < DEPTH);
   end else begin : g_wire
      assign dout = din;
      a_r3_tap_zero: assert property (@(posedge clk) disable iff (!rst_n)
         tap == '0);
   end

endmodule

// File: rtl/vof_clip.sv
module vof_clip #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dout <= '0;
      else if (din < lo)  dout <= lo;
      else if (din > hi)  dout <= hi;
      else                dout <= din;
   end

   // R6 and R7: every registered sample lies inside the limits in force.
   a_r7_clip_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (dout >= $past(lo) && dout <= $past(hi)));

   a_r8_in_range_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (din >= lo && din <= hi) |=> (dout == $past(din)));

endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
   import vof_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MAX_SHIFT = 3,
   parameter int WIDE_LO   = 1,
   parameter int WIDE_HI   = 254,
   parameter int NARROW_LO = 16,
   parameter int Y_NAR_HI  = 235,
   parameter int C_NAR_HI  = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              err_mode,
   input  logic [DATA_W-1:0] y_in,
   input  logic [DATA_W-1:0] c_in,
   input  logic              act_in,
   output logic [DATA_W-1:0] y_out,
   output logic [DATA_W-1:0] c_out,
   output logic              act_out
);

   localparam int BASE_LAT = MAX_SHIFT;
   localparam int N_TAPS   = 2 * MAX_SHIFT + 1;
   localparam int TAP_W    = $clog2(N_TAPS);

   if (MAX_SHIFT < 1 || MAX_SHIFT > 3) begin : g_bad_shift
      $error("vid_out_fmt: MAX_SHIFT must fit a 3-bit signed field");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("vid_out_fmt: DATA_W below 8 cannot hold the clamp limits");
   end
   if (WIDE_LO > WIDE_HI || NARROW_LO > Y_NAR_HI || NARROW_LO > C_NAR_HI) begin : g_bad_lim
      $error("vid_out_fmt: clamp limits out of order");
   end

   logic [2:0]        eff_act_code;
   logic [2:0]        eff_yc_code;
   logic              eff_range_sel;
   logic [TAP_W-1:0]  y_tap, c_tap, a_tap;
   logic [DATA_W-1:0] y_sel, c_sel;
   logic [0:0]        a_sel;
   logic [DATA_W-1:0] y_lo, y_hi, c_lo, c_hi;
   int                yc_off, act_off;

   vof_cfg_reg u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .we            (cfg_we),
      .wdata         (cfg_wdata),
      .rdata         (cfg_rdata),
      .err_mode      (err_mode),
      .act_in        (act_in),
      .eff_act_code  (eff_act_code),
      .eff_yc_code   (eff_yc_code),
      .eff_range_sel (eff_range_sel)
   );

   // Tap selection: base latency plus or minus the signed offsets.
   always_comb begin
      yc_off  = code_to_offset(eff_yc_code, MAX_SHIFT);
      act_off = code_to_offset(eff_act_code, MAX_SHIFT);
      y_tap   = TAP_W'(BASE_LAT + ((yc_off < 0) ? -yc_off : 0));
      c_tap   = TAP_W'(BASE_LAT + ((yc_off > 0) ? yc_off : 0));
      a_tap   = TAP_W'(BASE_LAT + act_off);
   end

   always_comb begin
      if (eff_range_sel) begin
         y_lo = DATA_W'(NARROW_LO);
         y_hi = DATA_W'(Y_NAR_HI);
         c_lo = DATA_W'(NARROW_LO);
         c_hi = DATA_W'(C_NAR_HI);
      end else begin
         y_lo = DATA_W'(WIDE_LO);
         y_hi = DATA_W'(WIDE_HI);
         c_lo = DATA_W'(WIDE_LO);
         c_hi = DATA_W'(WIDE_HI);
      end
   end

   vof_tap_line #(.W(DATA_W), .DEPTH(N_TAPS)) u_y_line (
      .clk(clk), .rst_n(rst_n), .din(y_in), .tap(y_tap), .dout(y_sel));

   vof_tap_line #(.W(DATA_W), .DEPTH(N_TAPS)) u_c_line (
      .clk(clk), .rst_n(rst_n), .din(c_in), .tap(c_tap), .dout(c_sel));

   vof_tap_line #(.W(1), .DEPTH(N_TAPS)) u_a_line (
      .clk(clk), .rst_n(rst_n), .din(act_in), .tap(a_tap), .dout(a_sel));

   vof_clip #(.W(DATA_W)) u_y_clip (
      .clk(clk), .rst_n(rst_n), .din(y_sel), .lo(y_lo), .hi(y_hi), .dout(y_out));

   vof_clip #(.W(DATA_W)) u_c_clip (
      .clk(clk), .rst_n(rst_n), .din(c_sel), .lo(c_lo), .hi(c_hi), .dout(c_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_out <= 1'b0;
      else        act_out <= a_sel[0];
   end

   // R4: the reserved code never moves a tap away from the base position.
   a_r4_null_code: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_yc_code == 3'b100) |-> (y_tap == TAP_W'(BASE_LAT) && c_tap == TAP_W'(BASE_LAT)));

   // R3: at most one of the two streams carries extra delay.
   a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      (y_tap == TAP_W'(BASE_LAT)) || (c_tap == TAP_W'(BASE_LAT)));

endmodule

// File: tb/vid_out_fmt_tb.sv
`timescale 1ns/1ps
module vid_out_fmt_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       err_mode;
   logic [7:0] y_in = '0, c_in = '0;
   logic       act_in = 1'b0;
   logic [7:0] y_out, c_out;
   logic       act_out;

   int checks = 0;
   int errors = 0;

   // Bench model state
   logic [7:0] hy [0:7];
   logic [7:0] hc [0:7];
   logic       ha [0:7];
   logic [7:0] m_cfg = '0;
   logic [2:0] sh_act = '0, sh_yc = '0;
   logic       sh_rng = 1'b0;
   logic       prev_a = 1'b0;
   int         m = 0;

   always #2.5 clk = ~clk;

   vid_out_fmt u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .err_mode(err_mode), .y_in(y_in), .c_in(c_in),
      .act_in(act_in), .y_out(y_out), .c_out(c_out), .act_out(act_out));

   function automatic int sdec(input logic [2:0] c);
      case (c)
         3'b001: return 1;
         3'b010: return 2;
         3'b011: return 3;
         3'b111: return -1;
         3'b110: return -2;
         3'b101: return -3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] lim(input logic [7:0] v, input int lo, input int hi);
      if (int'(v) < lo) return 8'(lo);
      if (int'(v) > hi) return 8'(hi);
      return v;
   endfunction

   function automatic logic [7:0] rnd8();
      int r;
      r = int'($urandom % 8);
      if (r == 0) return 8'd0;
      if (r == 1) return 8'd255;
      return 8'($urandom);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act, exp, m);
      end
   endtask

   task automatic step(input logic [7:0] yv, input logic [7:0] cv, input logic av,
                       input logic we, input logic [7:0] wd, input string tag);
      int ysh, ash, ky, kc, ka;
      logic [7:0] ey, ec;
      logic ea;
      y_in = yv; c_in = cv; act_in = av; cfg_we = we; cfg_wdata = wd;
      @(posedge clk);
      hy[m & 7] = yv; hc[m & 7] = cv; ha[m & 7] = av;
      ysh = sdec(sh_yc);
      ash = sdec(sh_act);
      ky = 3 + ((ysh < 0) ? -ysh : 0);
      kc = 3 + ((ysh > 0) ? ysh : 0);
      ka = 3 + ash;
      ey = sh_rng ? lim(hy[(m - ky) & 7], 16, 235) : lim(hy[(m - ky) & 7], 1, 254);
      ec = sh_rng ? lim(hc[(m - kc) & 7], 16, 240) : lim(hc[(m - kc) & 7], 1, 254);
      ea = ha[(m - ka) & 7];
      if (av && !prev_a) begin
         sh_act = m_cfg[7:5];
         sh_yc  = m_cfg[4:2];
         sh_rng = m_cfg[1];
      end
      if (we) m_cfg = wd;
      prev_a = av;
      m++;
      @(negedge clk);
      check(tag, "y_out", int'(y_out), int'(ey));
      check(tag, "c_out", int'(c_out), int'(ec));
      check(tag, "act_out", int'(act_out), int'(ea));
      check("R1", "cfg_rdata", int'(cfg_rdata), int'(m_cfg));
      check("R2", "err_mode", int'(err_mode), int'(m_cfg[0]));
   endtask

   // wr_at: -1 no write, -2 write on first blank cycle, else active index.
   task automatic run_line(input int nblank, input int nact, input string tag,
                           input int wr_at, input logic [7:0] wd);
      for (int i = 0; i < nblank; i++)
         step(rnd8(), rnd8(), 1'b0, (wr_at == -2 && i == 0), wd, tag);
      for (int i = 0; i < nact; i++)
         step(rnd8(), rnd8(), 1'b1, (wr_at == i), wd, tag);
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog expired at cycle %0d", m);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_0c1));
      for (int i = 0; i < 8; i++) begin hy[i] = '0; hc[i] = '0; ha[i] = 1'b0; end
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "y_out reset", int'(y_out), 0);
      check("R10", "c_out reset", int'(c_out), 0);
      check("R10", "act_out reset", int'(act_out), 0);
      check("R1", "cfg_rdata reset", int'(cfg_rdata), 0);
      rst_n = 1'b1;
      // R6: wide range, default settings, extremes included
      run_line(4, 20, "R6", -1, 8'h00);
      step(8'd0, 8'd255, 1'b1, 1'b0, 8'h00, "R6");
      step(8'd255, 8'd0, 1'b1, 1'b0, 8'h00, "R6");
      step(8'd1, 8'd254, 1'b1, 1'b0, 8'h00, "R6");
      // R7: narrow range
      run_line(4, 20, "R7", -2, 8'h02);
      step(8'd236, 8'd240, 1'b1, 1'b0, 8'h00, "R7");
      step(8'd235, 8'd241, 1'b1, 1'b0, 8'h00, "R7");
      step(8'd15, 8'd15, 1'b1, 1'b0, 8'h00, "R7");
      step(8'd255, 8'd255, 1'b1, 1'b0, 8'h00, "R7");
      run_line(4, 20, "R7", -1, 8'h00);
      // R3: every nonzero skew code
      foreach (sdec_codes[i]) run_line(5, 20, "R3", -2, {3'b000, sdec_codes[i], 2'b00});
      // R4: reserved code in both signed fields
      run_line(5, 20, "R4", -2, 8'b100_100_00);
      run_line(5, 20, "R4", -1, 8'h00);
      // R5: every nonzero active-start code
      foreach (sdec_codes[i]) run_line(5, 20, "R5", -2, {sdec_codes[i], 5'b00000});
      // R2: mode bit does not disturb the video path
      run_line(5, 20, "R2", -2, 8'h01);
      run_line(5, 20, "R2", -1, 8'h00);
      // R9: mid-line write waits for the next line start
      run_line(5, 12, "R9", -2, 8'h00);
      run_line(5, 30, "R9", 10, 8'b101_011_10);
      run_line(5, 30, "R9", 6, 8'b011_101_00);
      run_line(5, 30, "R9", -1, 8'h00);
      // R8: random mixes of all settings
      for (int l = 0; l < 80; l++) begin
         int nb, na, wa;
         nb = 3 + int'($urandom % 8);
         na = 8 + int'($urandom % 40);
         wa = ($urandom % 2 == 0) ? -1 : (int'($urandom % (na + 1)) - 1);
         if (wa == -1 && ($urandom % 3 == 0)) wa = -2;
         run_line(nb, na, "R8", wa, 8'($urandom));
      end
      run_line(8, 0, "R8", -1, 8'h00);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   logic [2:0] sdec_codes [6] = '{3'b001, 3'b010, 3'b011, 3'b111, 3'b110, 3'b101};

endmodule